// File: doc/BRIEF.md
# Real-Time Periodic Interrupt Generator

This block produces a periodic interrupt request from the bus clock. A counter tracks how many bus cycles have passed since the last expiry. When the selected period has elapsed, the counter sets a sticky timeout flag and starts the next period from that instant. A two-bit rate code chooses the period: the base period shifted left by the code. With the default base of 8192 cycles this gives 8192, 16384, 32768 or 65536 cycles.

Software sees three byte registers on a simple write strobe and a combinational read port. The control register holds the rate code in its two low bits and keeps the other six bits unchanged. The mask register holds the interrupt enable. The status register holds the flag, which is cleared by writing a one to its bit. The interrupt request is the flag gated by the enable.

A rate change takes effect for the period already running and is timed from the previous expiry. The timing therefore does not drift, and a rate write never raises the flag by itself. The register port is a plain strobe interface with no stream data, so there is no valid/ready handshake and no back-pressure.

Top module: `rti_gen`

## Requirements
- R1: The expiry period in bus cycles is BASE_PERIOD shifted left by the rate code (control register bits [1:0]); with BASE_PERIOD = 16, codes 0..3 give 16, 32, 64 and 128 cycles between expiries.
- R2: An expiry sets the status flag (status register, address 2, bit 6) on the next clock edge, and the next period is counted from that expiry.
- R3: A write to the control register never sets the flag by itself. The new period is measured from the previous expiry. If the new period minus one is already less than or equal to the elapsed count at the write, the expiry happens on the edge after the write.
- R4: Writing the status register with bit 6 set clears the flag.
- R5: Writing the status register with bit 6 clear leaves the flag unchanged. If an expiry and a clearing write land on the same edge, the flag stays set.
- R6: The irq output is high exactly when the flag is set and mask register (address 1) bit 6 is set.
- R7: The control register (address 0) stores and reads back all eight written bits; only bits [1:0] select the rate.
- R8: The mask register stores and reads back all eight written bits.
- R9: Reset clears the control, mask and status registers and irq, and restarts period timing; the first expiry after reset release comes BASE_PERIOD cycles later.
- R10: The status register reads bit 6 as the flag and all other bits as 0. Address 3 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 mask, 2 status |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| irq | output | 1 | Interrupt request, flag gated by enable |

## Verification
The assertions check on every cycle that the flag rises only after the counter reports an expiry. They also check that every expiry sets it, that clearing and ignored writes behave as specified, and that irq never appears without the flag. Period lengths for each rate can only be shown by the bench's scenarios. So can timing from the previous expiry across a rate change, the overdue case that fires one edge after the write, and the restart of timing after reset. The bench measures these as edge counts between observed expiries.

// File: rtl/rti_pkg.sv
package rti_pkg;
  localparam int RATE_W   = 2;
  localparam int FLAG_BIT = 6;
  localparam int ADDR_W   = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;
  typedef logic [7:0] reg_byte_t;
endpackage

// File: rtl/rti_rate_decode.sv
module rti_rate_decode
  import rti_pkg::*;
#(
  parameter int BASE_PERIOD = 8192,
  parameter int CNT_W       = 16
) (
  input  logic [RATE_W-1:0] rate,
  output logic [CNT_W-1:0]  period_m1
);
  localparam int LEVELS = 1 << RATE_W;
  logic [CNT_W-1:0] tbl [LEVELS];

  // One terminal count per rate code, computed at elaboration.
  for (genvar i = 0; i < LEVELS; i++) begin : g_tbl
    assign tbl[i] = CNT_W'((BASE_PERIOD << i) - 1);
  end

  assign period_m1 = tbl[rate];
endmodule

// File: rtl/rti_period_ctr.sv
module rti_period_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_m1,
  output logic             expire,
  output logic [CNT_W-1:0] elapsed
);
  // Greater-or-equal so that a shortened period that is already overdue
  // fires at once instead of wrapping the counter.
  assign expire = (elapsed >= period_m1);

  always_ff @(posedge clk) begin
    if (!rst_n)      elapsed <= '0;
    else if (expire) elapsed <= '0;
    else             elapsed <= elapsed + 1'b1;
  end
endmodule

// File: rtl/rti_regs.sv
module rti_regs
  import rti_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  reg_byte_t         wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              expire,
  output reg_byte_t         rd_data,
  output logic [RATE_W-1:0] rate,
  output logic              flag,
  output logic              irq
);
  reg_byte_t ctrl_q;
  reg_byte_t mask_q;
  logic      clr_req;

  assign clr_req = wr_en && (wr_addr == ADDR_STAT) && wr_data[FLAG_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_CTRL) ctrl_q <= wr_data;
      if (wr_addr == ADDR_MASK) mask_q <= wr_data;
    end
  end

  // Expiry has priority over a same-edge clear.
  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (expire)  flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      ADDR_CTRL: rd_data = ctrl_q;
      ADDR_MASK: rd_data = mask_q;
      ADDR_STAT: rd_data[FLAG_BIT] = flag;
      default:   rd_data = '0;
    endcase
  end

  assign rate = ctrl_q[RATE_W-1:0];
  assign irq  = flag & mask_q[FLAG_BIT];
endmodule

// File: rtl/rti_gen.sv
module rti_gen
  import rti_pkg::*;
#(
  parameter int BASE_PERIOD = 8192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       irq
);
  localparam int CNT_W = $clog2(BASE_PERIOD) + (1 << RATE_W) - 1;

  logic [RATE_W-1:0] rate;
  logic [CNT_W-1:0]  period_m1;
  logic [CNT_W-1:0]  elapsed;
  logic              expire;
  logic              flag;

  rti_rate_decode #(.BASE_PERIOD(BASE_PERIOD), .CNT_W(CNT_W)) u_dec (
    .rate      (rate),
    .period_m1 (period_m1)
  );

  rti_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .period_m1 (period_m1),
    .expire    (expire),
    .elapsed   (elapsed)
  );

  rti_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .expire  (expire),
    .rd_data (rd_data),
    .rate    (rate),
    .flag    (flag),
    .irq     (irq)
  );
endmodule

// File: rtl/rti_gen_chk.sv
module rti_gen_chk
  import rti_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       expire,
  input logic       flag,
  input logic       irq
);
  logic clr_wr;
  assign clr_wr = wr_en && (wr_addr == ADDR_STAT) && wr_data[FLAG_BIT];

  // R2
  expire_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);

  // R3
  flag_only_from_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(expire));

  // R4
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !expire) |=> !flag);

  // R5
  flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_wr) |=> flag);

  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
endmodule

bind rti_gen rti_gen_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .expire  (expire),
  .flag    (flag),
  .irq     (irq)
);

// File: tb/sim_rti_gen.sv
`timescale 1ns/1ps
module sim_rti_gen;
  localparam int B = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rti_gen #(.BASE_PERIOD(B)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Entered at a negedge; the write lands on the next posedge.
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic clear_flag();
    wr(2'd2, 8'h40);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic wait_flag(input string req, output int e);
    int n = 0;
    rd_addr = 2'd2;
    do begin
      @(negedge clk);
      n++;
    end while (!rd_data[6] && n < 1000);
    if (n >= 1000) chk(1'b0, req, 0, 1);
    e = cyc;
  endtask

  task automatic do_reset(output int r);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    r = cyc;
  endtask

  task automatic t_reset();
    int r, e;
    logic [7:0] v;
    do_reset(r);
    rd(2'd0, v); chk(v == 8'h00, "R9 ctrl", v, 0);
    rd(2'd1, v); chk(v == 8'h00, "R9 mask", v, 0);
    rd(2'd2, v); chk(v == 8'h00, "R9 status", v, 0);
    chk(irq == 1'b0, "R9 irq", irq, 0);
    wait_flag("R9 first expiry", e);
    chk(e - r == B, "R9 first expiry delay", e - r, B);
  endtask

  task automatic t_rates();
    int e1, e2;
    for (int k = 0; k < 4; k++) begin
      wr(2'd0, 8'(k));
      clear_flag();
      wait_flag("R1 wait", e1);
      clear_flag();
      wait_flag("R1 wait", e2);
      clear_flag();
      chk(e2 - e1 == (B << k), "R1 R2 period", e2 - e1, B << k);
    end
  endtask

  task automatic t_retime();
    int e1, e2;
    logic [7:0] v;
    wr(2'd0, 8'h02);
    clear_flag();
    wait_flag("R3 wait", e1);
    clear_flag();
    wait_until(e1 + 8);
    wr(2'd0, 8'h00);
    rd(2'd2, v); chk(v[6] == 1'b0, "R3 write sets no flag", v[6], 0);
    wait_flag("R3 wait", e2);
    chk(e2 - e1 == B, "R3 retimed from prior expiry", e2 - e1, B);
    // overdue case
    wr(2'd0, 8'h03);
    clear_flag();
    wait_flag("R3 wait", e1);
    clear_flag();
    wait_until(e1 + 40);
    wr(2'd0, 8'h00);
    rd(2'd2, v); chk(v[6] == 1'b0, "R3 overdue write sets no flag", v[6], 0);
    wait_flag("R3 wait", e2);
    chk(e2 - e1 == 42, "R3 overdue expiry", e2 - e1, 42);
    clear_flag();
  endtask

  task automatic t_w1c();
    int e1;
    logic [7:0] v;
    wr(2'd0, 8'h03);
    clear_flag();
    wait_flag("R4 wait", e1);
    rd(2'd2, v); chk(v == 8'h40, "R10 status other bits", v, 8'h40);
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk(v[6] == 1'b1, "R5 write zero", v[6], 1);
    wr(2'd2, 8'hBF);
    rd(2'd2, v); chk(v[6] == 1'b1, "R5 write other bits", v[6], 1);
    wr(2'd2, 8'h40);
    rd(2'd2, v); chk(v[6] == 1'b0, "R4 write one clears", v[6], 0);
  endtask

  task automatic t_collision();
    int e1;
    logic [7:0] v;
    wr(2'd0, 8'h00);
    clear_flag();
    wait_flag("R5 wait", e1);
    clear_flag();
    wait_until(e1 + 15);
    wr(2'd2, 8'h40);
    rd(2'd2, v); chk(v[6] == 1'b1, "R5 set beats clear", v[6], 1);
    chk(cyc == e1 + 16, "R5 collision edge", cyc, e1 + 16);
    clear_flag();
  endtask

  task automatic t_irq();
    int e1;
    logic [7:0] v;
    wr(2'd0, 8'h03);
    clear_flag();
    wr(2'd1, 8'hFF);
    rd(2'd1, v); chk(v == 8'hFF, "R8 mask readback", v, 8'hFF);
    chk(irq == 1'b0, "R6 irq without flag", irq, 0);
    wr(2'd1, 8'hBF);
    wait_flag("R6 wait", e1);
    chk(irq == 1'b0, "R6 irq masked", irq, 0);
    wr(2'd1, 8'h40);
    chk(irq == 1'b1, "R6 irq enabled", irq, 1);
    clear_flag();
    chk(irq == 1'b0, "R6 irq after clear", irq, 0);
  endtask

  task automatic t_ctrl();
    int e1, e2;
    logic [7:0] v;
    wr(2'd0, 8'hA5);
    rd(2'd0, v); chk(v == 8'hA5, "R7 ctrl readback", v, 8'hA5);
    clear_flag();
    wait_flag("R7 wait", e1);
    clear_flag();
    wait_flag("R7 wait", e2);
    chk(e2 - e1 == 2 * B, "R7 rate from low bits", e2 - e1, 2 * B);
    clear_flag();
    wr(2'd3, 8'hFF);
    rd(2'd3, v); chk(v == 8'h00, "R10 addr3 reads zero", v, 0);
    rd(2'd0, v); chk(v == 8'hA5, "R10 addr3 write ignored ctrl", v, 8'hA5);
    rd(2'd1, v); chk(v == 8'h40, "R10 addr3 write ignored mask", v, 8'h40);
    rd(2'd2, v); chk(v == 8'h00, "R10 addr3 write ignored status", v, 0);
  endtask

  task automatic t_reset_mid();
    int r, e, e1;
    logic [7:0] v;
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h40);
    clear_flag();
    wait_flag("R9 wait", e1);
    chk(irq == 1'b1, "R6 irq before reset", irq, 1);
    repeat (30) @(negedge clk);
    do_reset(r);
    rd(2'd0, v); chk(v == 8'h00, "R9 ctrl after mid reset", v, 0);
    rd(2'd2, v); chk(v == 8'h00, "R9 flag after mid reset", v, 0);
    chk(irq == 1'b0, "R9 irq after mid reset", irq, 0);
    wait_flag("R9 wait", e);
    chk(e - r == B, "R9 timing restarted", e - r, B);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_rates();
    t_retime();
    t_w1c();
    t_collision();
    t_irq();
    t_ctrl();
    t_reset_mid();
    summary();
    $finish;
  end
endmodule